// File: doc/BRIEF.md
# APB Register Bank with Write Strobes

This block is the software-visible register file of a peripheral. An APB3 slave port gives the processor access to a small map of 32-bit words. Some of these words hold control fields that the processor writes and the peripheral logic reads. Some report counters that the peripheral logic drives. The rest are fixed words that identify the build: two magic words, a packed pair of 16-bit markers, a build date, a build time, and a checksum computed over the map's own layout. Driver software reads the checksum and compares it with the value in its header. A mismatch means the software and the hardware come from different builds.

Three of the rows are status rows. Each has a one-cycle write strobe toward the fabric. Software can write such a row to acknowledge or clear something, and the fabric learns of that write at once. Apart from one read-write sticky bit in the first status row, the data written to these rows is discarded.

Bus phases are tracked by a three-state machine. PH_IDLE moves to PH_SETUP on a cycle with PSEL high and PENABLE low. PH_SETUP moves to PH_ACCESS on PSEL and PENABLE both high, stays in PH_SETUP while PSEL is high and PENABLE is low, and otherwise returns to PH_IDLE. PH_ACCESS moves to PH_SETUP on a new setup cycle and otherwise returns to PH_IDLE. A transfer takes effect only in an access cycle seen while the state is PH_SETUP.

Top module: `regbank_apb`

## Requirements
- R1: While PRESETn is low and after reset, every read-write field is zero. `wr_flag` is 0 outside a committed write. PREADY is always 1 and PSLVERR is always 0.
- R2: A transfer is committed only in a cycle with PSEL=1 and PENABLE=1 that directly follows a cycle with PSEL=1 and PENABLE=0. A cycle with PSEL and PENABLE both high that follows an idle cycle changes no register and raises no strobe.
- R3: The row index is PADDR[ADDR_W-1:2], and PADDR[1:0] is ignored. With NUM_BASE=2 the map is as follows. Row 0 is control. Rows 1–2 are base words. Rows 3, 4 and 5 are the status rows A, B and C. Row 6 is the build date and row 7 the build time. Rows 8 and 9 are the magic words. Row 10 is the pair. Row 11 is the checksum. Rows 0..11 are at byte addresses 0x00..0x2C.
- R4: The control row holds `run_en` in bit 0 and `addr_sel` in bit 1. Both can be written and read back. Bits 31:2 read as 0.
- R5: Status row A reads {overrun, reply_cnt[22:0], frame_cnt[7:0]}, most significant bit first. Row B reads {toggle_cnt[15:0], line_cnt[15:0]}. Row C reads valid_cnt[31:0]. All status values are the live fabric inputs.
- R6: In status row A, a write changes bit 31 (`overrun`) only. Writes to rows B and C, and to any constant, date, time or checksum row, change no read value.
- R7: The magic rows read 0xDEADBEEF and 0xCAFEBABE. The pair row reads 0xBEEFCAFE, with 0xCAFE in bits 15:0 and 0xBEEF in bits 31:16.
- R8: The date row reads the BUILD_DATE parameter and the time row reads the BUILD_TIME parameter.
- R9: The checksum row reads the 32-bit sum over rows k = 0..10 of (k+1)·(rw_k + 3·ro_k + c_k), taken modulo 2^32. In this sum, rw_k is the row's read-write bit mask, ro_k its fabric-driven bit mask, and c_k its fixed value (date, time, magic or pair, otherwise 0).
- R10: `wr_flag[0]`, `wr_flag[1]` and `wr_flag[2]` go high combinationally during a committed write to status row A, B and C respectively. Each lasts exactly that one cycle. Reads and writes to other rows leave `wr_flag` at 0.
- R11: A read of a row index beyond the checksum row returns 0. A write there changes nothing.
- R12: Each base row is a full 32-bit read-write word driving its own slice of `ctl_base`. A write to one base row leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the addressed row |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ctl_run_en | output | 1 | Control row bit 0 |
| ctl_addr_sel | output | 1 | Control row bit 1 |
| ctl_base | output | 32·NUM_BASE | Base words; row 1 is bits 31:0 |
| ctl_overrun | output | 1 | Sticky bit 31 of status row A |
| st_frame_cnt | input | 8 | Status A low field |
| st_reply_cnt | input | 23 | Status A middle field |
| st_line_cnt | input | 16 | Status B low half |
| st_toggle_cnt | input | 16 | Status B high half |
| st_valid_cnt | input | 32 | Status C word |
| wr_flag | output | 3 | Write strobes for status rows A, B, C |

## Verification
The assertions assume that the bus master follows the APB3 order: a setup cycle, one access cycle, and a PADDR that stays unchanged through both. They also assume that the status inputs change only between transfers, so a read value and the strobe it is checked against belong to the same row. The bench drives every transfer through one task. That task always produces the setup-then-access pair with stable address and data and holds the status inputs fixed. The single deliberate violation is an access cycle with no setup before it, used to show that such a cycle is rejected.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    typedef enum logic [3:0] {
        RK_CTRL,
        RK_BASE,
        RK_STAT_A,
        RK_STAT_B,
        RK_STAT_C,
        RK_DATE,
        RK_TIME,
        RK_MAGIC0,
        RK_MAGIC1,
        RK_PAIR,
        RK_CSUM,
        RK_NONE
    } row_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACCESS
    } apb_phase_e;

    localparam int          FIXED_ROWS  = 10;
    localparam int          FLAG_ROWS   = 3;
    localparam logic [31:0] MAGIC0_WORD = 32'hDEAD_BEEF;
    localparam logic [31:0] MAGIC1_WORD = 32'hCAFE_BABE;
    localparam logic [15:0] PAIR_LOW    = 16'hCAFE;
    localparam logic [15:0] PAIR_HIGH   = 16'hBEEF;
    localparam logic [31:0] CTRL_RW     = 32'h0000_0003;
    localparam logic [31:0] STAT_A_RW   = 32'h8000_0000;

    function automatic int row_count(input int nbase);
        return nbase + FIXED_ROWS;
    endfunction

    function automatic row_kind_e row_kind(input int idx, input int nbase);
        row_kind_e k;
        if (idx == 0)
            k = RK_CTRL;
        else if (idx <= nbase)
            k = RK_BASE;
        else begin
            case (idx - nbase)
                1:       k = RK_STAT_A;
                2:       k = RK_STAT_B;
                3:       k = RK_STAT_C;
                4:       k = RK_DATE;
                5:       k = RK_TIME;
                6:       k = RK_MAGIC0;
                7:       k = RK_MAGIC1;
                8:       k = RK_PAIR;
                9:       k = RK_CSUM;
                default: k = RK_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic row_kind_e flag_kind(input int f);
        row_kind_e k;
        case (f)
            0:       k = RK_STAT_A;
            1:       k = RK_STAT_B;
            default: k = RK_STAT_C;
        endcase
        return k;
    endfunction

    function automatic logic [31:0] rw_mask(input row_kind_e k);
        logic [31:0] m;
        case (k)
            RK_CTRL:   m = CTRL_RW;
            RK_BASE:   m = 32'hFFFF_FFFF;
            RK_STAT_A: m = STAT_A_RW;
            default:   m = 32'h0;
        endcase
        return m;
    endfunction

    function automatic logic [31:0] ro_mask(input row_kind_e k);
        logic [31:0] m;
        case (k)
            RK_STAT_A: m = ~STAT_A_RW;
            RK_STAT_B: m = 32'hFFFF_FFFF;
            RK_STAT_C: m = 32'hFFFF_FFFF;
            default:   m = 32'h0;
        endcase
        return m;
    endfunction

    function automatic logic [31:0] fixed_word(input row_kind_e k,
                                               input logic [31:0] date,
                                               input logic [31:0] tod);
        logic [31:0] w;
        case (k)
            RK_DATE:   w = date;
            RK_TIME:   w = tod;
            RK_MAGIC0: w = MAGIC0_WORD;
            RK_MAGIC1: w = MAGIC1_WORD;
            RK_PAIR:   w = {PAIR_HIGH, PAIR_LOW};
            default:   w = 32'h0;
        endcase
        return w;
    endfunction

    function automatic logic [31:0] map_checksum(input int nbase,
                                                 input logic [31:0] date,
                                                 input logic [31:0] tod);
        logic [31:0] acc;
        logic [31:0] term;
        row_kind_e   k;
        acc = 32'h0;
        for (int r = 0; r < row_count(nbase) - 1; r++) begin
            k    = row_kind(r, nbase);
            term = rw_mask(k) + 32'd3 * ro_mask(k) + fixed_word(k, date, tod);
            acc  = acc + 32'(r + 1) * term;
        end
        return acc;
    endfunction

endpackage

// File: rtl/regbank_phase_fsm.sv
module regbank_phase_fsm
    import regbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       psel,
    input  logic       penable,
    input  logic       pwrite,
    output logic       wr_commit,
    output apb_phase_e phase
);

    apb_phase_e state_q;
    apb_phase_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PH_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = PH_IDLE;
        unique case (state_q)
            PH_IDLE: begin
                if (psel && !penable)
                    state_d = PH_SETUP;
            end
            PH_SETUP: begin
                if (psel && penable)
                    state_d = PH_ACCESS;
                else if (psel)
                    state_d = PH_SETUP;
            end
            PH_ACCESS: begin
                if (psel && !penable)
                    state_d = PH_SETUP;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        wr_commit = 1'b0;
        unique case (state_q)
            PH_SETUP:  wr_commit = psel && penable && pwrite;
            PH_IDLE,
            PH_ACCESS: wr_commit = 1'b0;
            default:   wr_commit = 1'b0;
        endcase
    end

    assign phase = state_q;

endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_BASE = 2,
    localparam int BSEL_W  = (NUM_BASE > 1) ? $clog2(NUM_BASE) : 1
) (
    input  logic [ADDR_W-1:0] paddr,
    output row_kind_e         kind,
    output logic [BSEL_W-1:0] base_sel
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] base_off;
    logic             unused_byte_lane;

    assign idx              = paddr[ADDR_W-1:2];
    assign unused_byte_lane = ^paddr[1:0];
    assign kind             = row_kind(int'(idx), NUM_BASE);
    assign base_off         = idx - IDX_W'(1);
    assign base_sel         = base_off[BSEL_W-1:0];

endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import regbank_pkg::*;
#(
    parameter int NUM_BASE = 2,
    localparam int BSEL_W  = (NUM_BASE > 1) ? $clog2(NUM_BASE) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_commit,
    input  row_kind_e               kind,
    input  logic [BSEL_W-1:0]       base_sel,
    input  logic [31:0]             wdata,
    output logic                    run_en,
    output logic                    addr_sel,
    output logic [NUM_BASE*32-1:0]  base,
    output logic                    overrun
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            addr_sel <= 1'b0;
        end else if (wr_commit && kind == RK_CTRL) begin
            run_en   <= wdata[0];
            addr_sel <= wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (wr_commit && kind == RK_STAT_A)
            overrun <= wdata[31];
    end

    for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                base[b*32 +: 32] <= 32'h0;
            else if (wr_commit && kind == RK_BASE && int'(base_sel) == b)
                base[b*32 +: 32] <= wdata;
        end
    end

endmodule

// File: rtl/regbank_apb.sv
module regbank_apb
    import regbank_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          NUM_BASE   = 2,
    parameter logic [31:0] BUILD_DATE = 32'h2000_0101,
    parameter logic [31:0] BUILD_TIME = 32'h0012_0000
) (
    input  logic                   pclk,
    input  logic                   presetn,
    input  logic                   psel,
    input  logic                   penable,
    input  logic                   pwrite,
    input  logic [ADDR_W-1:0]      paddr,
    input  logic [31:0]            pwdata,
    output logic [31:0]            prdata,
    output logic                   pready,
    output logic                   pslverr,
    output logic                   ctl_run_en,
    output logic                   ctl_addr_sel,
    output logic [NUM_BASE*32-1:0] ctl_base,
    output logic                   ctl_overrun,
    input  logic [7:0]             st_frame_cnt,
    input  logic [22:0]            st_reply_cnt,
    input  logic [15:0]            st_line_cnt,
    input  logic [15:0]            st_toggle_cnt,
    input  logic [31:0]            st_valid_cnt,
    output logic [FLAG_ROWS-1:0]   wr_flag
);

    localparam int          BSEL_W   = (NUM_BASE > 1) ? $clog2(NUM_BASE) : 1;
    localparam logic [31:0] CSUM_VAL = map_checksum(NUM_BASE, BUILD_DATE, BUILD_TIME);

    row_kind_e         kind;
    logic [BSEL_W-1:0] base_sel;
    logic              wr_commit;
    apb_phase_e        phase;
    apb_phase_e        unused_phase;

    regbank_phase_fsm i_fsm (
        .clk       (pclk),
        .rst_n     (presetn),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .wr_commit (wr_commit),
        .phase     (phase)
    );
    assign unused_phase = phase;

    regbank_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_BASE (NUM_BASE)
    ) i_decode (
        .paddr    (paddr),
        .kind     (kind),
        .base_sel (base_sel)
    );

    regbank_store #(
        .NUM_BASE (NUM_BASE)
    ) i_store (
        .clk       (pclk),
        .rst_n     (presetn),
        .wr_commit (wr_commit),
        .kind      (kind),
        .base_sel  (base_sel),
        .wdata     (pwdata),
        .run_en    (ctl_run_en),
        .addr_sel  (ctl_addr_sel),
        .base      (ctl_base),
        .overrun   (ctl_overrun)
    );

    always_comb begin
        prdata = 32'h0;
        unique case (kind)
            RK_CTRL:   prdata = {30'h0, ctl_addr_sel, ctl_run_en};
            RK_BASE:   prdata = ctl_base[int'(base_sel)*32 +: 32];
            RK_STAT_A: prdata = {ctl_overrun, st_reply_cnt, st_frame_cnt};
            RK_STAT_B: prdata = {st_toggle_cnt, st_line_cnt};
            RK_STAT_C: prdata = st_valid_cnt;
            RK_DATE,
            RK_TIME,
            RK_MAGIC0,
            RK_MAGIC1,
            RK_PAIR:   prdata = fixed_word(kind, BUILD_DATE, BUILD_TIME);
            RK_CSUM:   prdata = CSUM_VAL;
            RK_NONE:   prdata = 32'h0;
            default:   prdata = 32'h0;
        endcase
    end

    for (genvar f = 0; f < FLAG_ROWS; f++) begin : g_flag
        assign wr_flag[f] = wr_commit && (kind == flag_kind(f));
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/regbank_apb_chk.sv
module regbank_apb_chk
    import regbank_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_BASE = 2
) (
    input logic                   pclk,
    input logic                   presetn,
    input logic                   psel,
    input logic                   penable,
    input logic                   pwrite,
    input logic [ADDR_W-1:0]      paddr,
    input logic [31:0]            pwdata,
    input logic [31:0]            prdata,
    input logic                   pready,
    input logic                   pslverr,
    input logic                   ctl_run_en,
    input logic                   ctl_addr_sel,
    input logic [NUM_BASE*32-1:0] ctl_base,
    input logic                   ctl_overrun,
    input logic [7:0]             st_frame_cnt,
    input logic [22:0]            st_reply_cnt,
    input logic [15:0]            st_line_cnt,
    input logic [15:0]            st_toggle_cnt,
    input logic [31:0]            st_valid_cnt,
    input logic [FLAG_ROWS-1:0]   wr_flag
);

    localparam int NROWS = row_count(NUM_BASE);

    logic [ADDR_W-3:0] idx;
    assign idx = paddr[ADDR_W-1:2];

    AST_BUS_RESPONSE: assert property (@(posedge pclk) disable iff (!presetn)
        pready && !pslverr);  // R1

    AST_RESET_CLEARS: assert property (@(posedge pclk)
        !presetn |=> (!ctl_run_en && !ctl_addr_sel && !ctl_overrun));  // R1

    AST_FLAG_ONE_ROW: assert property (@(posedge pclk) disable iff (!presetn)
        $onehot0(wr_flag));  // R10

    AST_FLAG_IN_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_flag != '0) |-> (psel && penable && pwrite));  // R10

    AST_FLAG_ONE_CYCLE: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_flag != '0) |=> (wr_flag == '0));  // R10

    AST_FLAG_AFTER_SETUP: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_flag != '0) |-> $past(psel && !penable));  // R2

    AST_CTRL_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable && pwrite) |=> ($stable(ctl_run_en) && $stable(ctl_addr_sel)));  // R4

    AST_BASE_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable && pwrite) |=> $stable(ctl_base));  // R12

    AST_MAGIC_READ: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && int'(idx) == NUM_BASE + 6) |-> (prdata == MAGIC0_WORD));  // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && int'(idx) >= NROWS) |-> (prdata == 32'h0));  // R11

endmodule

bind regbank_apb regbank_apb_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_BASE (NUM_BASE)
) i_regbank_apb_chk (.*);

// File: tb/test_regbank_apb.sv
module test_regbank_apb;

    localparam logic [31:0] T_DATE = 32'h2024_0611;
    localparam logic [31:0] T_TIME = 32'h0014_3005;

    localparam logic [7:0]  V_FRAME  = 8'h5A;
    localparam logic [22:0] V_REPLY  = 23'h12_3456;
    localparam logic [15:0] V_LINE   = 16'h1357;
    localparam logic [15:0] V_TOGGLE = 16'h2468;
    localparam logic [31:0] V_VALID  = 32'h0BAD_F00D;

    // R9 expected checksum from the requirement's formula
    localparam logic [31:0] EXP_CSUM =
          32'd1  * 32'h0000_0003
        + 32'd2  * 32'hFFFF_FFFF
        + 32'd3  * 32'hFFFF_FFFF
        + 32'd4  * (32'h8000_0000 + 32'd3 * 32'h7FFF_FFFF)
        + 32'd5  * (32'd3 * 32'hFFFF_FFFF)
        + 32'd6  * (32'd3 * 32'hFFFF_FFFF)
        + 32'd7  * T_DATE
        + 32'd8  * T_TIME
        + 32'd9  * 32'hDEAD_BEEF
        + 32'd10 * 32'hCAFE_BABE
        + 32'd11 * 32'hBEEF_CAFE;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        ctl_run_en;
    logic        ctl_addr_sel;
    logic [63:0] ctl_base;
    logic        ctl_overrun;
    logic [2:0]  wr_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 pclk = ~pclk;

    regbank_apb #(
        .ADDR_W     (12),
        .NUM_BASE   (2),
        .BUILD_DATE (T_DATE),
        .BUILD_TIME (T_TIME)
    ) i_regbank_apb (
        .pclk          (pclk),
        .presetn       (presetn),
        .psel          (psel),
        .penable       (penable),
        .pwrite        (pwrite),
        .paddr         (paddr),
        .pwdata        (pwdata),
        .prdata        (prdata),
        .pready        (pready),
        .pslverr       (pslverr),
        .ctl_run_en    (ctl_run_en),
        .ctl_addr_sel  (ctl_addr_sel),
        .ctl_base      (ctl_base),
        .ctl_overrun   (ctl_overrun),
        .st_frame_cnt  (V_FRAME),
        .st_reply_cnt  (V_REPLY),
        .st_line_cnt   (V_LINE),
        .st_toggle_cnt (V_TOGGLE),
        .st_valid_cnt  (V_VALID),
        .wr_flag       (wr_flag)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;   // write data, or expected read data
        logic [2:0]  flag;   // expected strobe in the access cycle
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 32'h0000_0000, 3'b000, 8'd1},   // R1 control reset value
        '{1'b1, 12'h000, 32'hFFFF_FFFF, 3'b000, 8'd4},   // R4
        '{1'b0, 12'h000, 32'h0000_0003, 3'b000, 8'd4},   // R4 reserved bits zero
        '{1'b0, 12'h002, 32'h0000_0003, 3'b000, 8'd3},   // R3 byte lane ignored
        '{1'b1, 12'h004, 32'h1234_5678, 3'b000, 8'd12},  // R12
        '{1'b1, 12'h008, 32'h89AB_CDEF, 3'b000, 8'd12},  // R12
        '{1'b0, 12'h004, 32'h1234_5678, 3'b000, 8'd12},  // R12 first base kept
        '{1'b0, 12'h008, 32'h89AB_CDEF, 3'b000, 8'd12},  // R12
        '{1'b0, 12'h00C, 32'h1234_565A, 3'b000, 8'd5},   // R5 status A
        '{1'b1, 12'h00C, 32'hFFFF_FFFF, 3'b001, 8'd10},  // R10 strobe A
        '{1'b0, 12'h00C, 32'h9234_565A, 3'b000, 8'd6},   // R6 only overrun taken
        '{1'b1, 12'h010, 32'h0000_0000, 3'b010, 8'd10},  // R10 strobe B
        '{1'b0, 12'h010, 32'h2468_1357, 3'b000, 8'd6},   // R6 status B unchanged
        '{1'b1, 12'h014, 32'hFFFF_FFFF, 3'b100, 8'd10},  // R10 strobe C
        '{1'b0, 12'h014, 32'h0BAD_F00D, 3'b000, 8'd6},   // R6 status C unchanged
        '{1'b1, 12'h018, 32'h0000_0000, 3'b000, 8'd6},   // R6
        '{1'b0, 12'h018, T_DATE,        3'b000, 8'd8},   // R8 date
        '{1'b1, 12'h01C, 32'hFFFF_FFFF, 3'b000, 8'd6},   // R6
        '{1'b0, 12'h01C, T_TIME,        3'b000, 8'd8},   // R8 time
        '{1'b1, 12'h020, 32'h0000_0000, 3'b000, 8'd6},   // R6
        '{1'b0, 12'h020, 32'hDEAD_BEEF, 3'b000, 8'd7},   // R7
        '{1'b0, 12'h024, 32'hCAFE_BABE, 3'b000, 8'd7},   // R7
        '{1'b1, 12'h028, 32'h0000_0000, 3'b000, 8'd6},   // R6
        '{1'b0, 12'h028, 32'hBEEF_CAFE, 3'b000, 8'd7},   // R7 pair halves
        '{1'b0, 12'h02C, EXP_CSUM,      3'b000, 8'd9},   // R9
        '{1'b1, 12'h02C, 32'h0000_0000, 3'b000, 8'd6},   // R6
        '{1'b0, 12'h02C, EXP_CSUM,      3'b000, 8'd9},   // R9 after write
        '{1'b1, 12'h030, 32'hFFFF_FFFF, 3'b000, 8'd11},  // R11
        '{1'b0, 12'h030, 32'h0000_0000, 3'b000, 8'd11},  // R11
        '{1'b0, 12'hFFC, 32'h0000_0000, 3'b000, 8'd11}   // R11 top address
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One APB transfer: setup cycle, access cycle, then idle.
    task automatic xfer(input logic wr, input logic [11:0] addr, input logic [31:0] data,
                        output logic [31:0] rd, output logic [2:0] flg, output logic [2:0] flg_after);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = data;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        rd  = prdata;
        flg = wr_flag;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1;
        flg_after = wr_flag;
    endtask

    initial begin
        logic [31:0] rd;
        logic [2:0]  flg;
        logic [2:0]  flg2;

        repeat (3) @(negedge pclk);
        // R1 reset state at the ports
        check("R1 run_en", {31'h0, ctl_run_en}, 32'h0);
        check("R1 base", ctl_base[31:0] | ctl_base[63:32], 32'h0);
        check("R1 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);
        presetn = 1'b1;

        for (int i = 0; i < NV; i++) begin
            xfer(VECS[i].wr, VECS[i].addr, VECS[i].data, rd, flg, flg2);
            if (VECS[i].wr)
                check($sformatf("R%0d strobe @%h", VECS[i].req, VECS[i].addr),
                      {29'h0, flg}, {29'h0, VECS[i].flag});
            else
                check($sformatf("R%0d read @%h", VECS[i].req, VECS[i].addr), rd, VECS[i].data);
            check("R10 strobe gone after access", {29'h0, flg2}, 32'h0);
        end

        // R4 / R12 fabric-side outputs follow the writes above
        check("R4 ctl bits", {30'h0, ctl_addr_sel, ctl_run_en}, 32'h3);
        check("R12 base0", ctl_base[31:0], 32'h1234_5678);
        check("R12 base1", ctl_base[63:32], 32'h89AB_CDEF);
        check("R6 overrun out", {31'h0, ctl_overrun}, 32'h1);

        // R2 access cycle with no setup before it: ignored
        @(negedge pclk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 12'h00C; pwdata = 32'h0;
        #1;
        check("R2 no strobe without setup", {29'h0, wr_flag}, 32'h0);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        xfer(1'b0, 12'h00C, 32'h0, rd, flg, flg2);
        check("R2 overrun kept", rd, 32'h9234_565A);

        // R10 reads never strobe
        xfer(1'b0, 12'h010, 32'h0, rd, flg, flg2);
        check("R10 read no strobe", {29'h0, flg}, 32'h0);

        // R1 reset in the middle of operation
        @(negedge pclk);
        presetn = 1'b0;
        @(negedge pclk);
        check("R1 reset clears ctl", {29'h0, ctl_overrun, ctl_addr_sel, ctl_run_en}, 32'h0);
        check("R1 reset clears base", ctl_base[31:0] | ctl_base[63:32], 32'h0);
        presetn = 1'b1;
        xfer(1'b0, 12'h000, 32'h0, rd, flg, flg2);
        check("R1 control reads zero", rd, 32'h0);
        xfer(1'b0, 12'h020, 32'h0, rd, flg, flg2);
        check("R7 constant after reset", rd, 32'hDEAD_BEEF);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge pclk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule